// File: doc/BRIEF.md
# Rotating Register File with Rename Base

This block is a 128-entry register file with two combinational read ports and one clocked write port. It is built for software-pipelined loops. Logical registers 0 to 31 are static: each one always addresses the physical entry with the same number. Logical registers 32 to 127 form a rotating window. Their physical entry is found by adding a rename base to the logical offset, modulo 96.

The rename base lives inside the block. A one-cycle rotate strobe models the side effect of a loop-closing branch. Each strobe lowers the base by one, so every value in the window appears one logical number higher than before, and the value at 127 comes back at 32. Software can also load the base directly. A design that has separate integer and floating-point files places one copy of this block per file, and each copy keeps its own base.

The base is updated by a small controller. On every edge it takes one of three actions:

- `BASE_HOLD`: neither the load nor the rotate is requested.
- `BASE_LOAD`: a direct load is requested. This action wins over a rotate.
- `BASE_STEP`: a rotate is requested and no load is.

Synchronous reset forces the base to 0. Reset has no fixed transition into any of the three actions.

Top module: `rot_regfile`

## Requirements
- R1: Both read ports return the current contents of the addressed logical register in the same cycle, with no clock edge in between. A write with `wr_en` high commits on the rising edge. After that edge, both read ports return the new value.
- R2: Logical register 0 always reads as zero on both ports. A write to logical 0 has no effect on any register.
- R3: Logical registers 1 to 31 map to physical entries 1 to 31 whatever the base is. Rotates and base loads never change what they read.
- R4: A logical register L of 32 or more maps to physical entry 32 + ((L − 32 + base) mod 96).
- R5: `rot_step` high, with `base_wr_en` low, lowers the base by one on the rising edge. A base of 0 becomes 95. The base is visible on `rot_base`.
- R6: After one rotate, the value that read at logical L (32 ≤ L ≤ 126) reads at L+1. The value that read at 127 reads at 32.
- R7: `base_wr_en` high loads `base_wr_val` mod 96 into the base on the rising edge. In a cycle where both are high, the load wins over `rot_step`.
- R8: A write in the same cycle as a rotate or a base load uses the mapping in effect before that edge.
- R9: Reset high at a rising edge sets the base to 0. The register contents are not defined after reset.
- R10: `rot_base` is always in the range 0 to 95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the base |
| rd_a_idx | input | 7 | Logical register number, read port A |
| rd_a_data | output | 64 | Data, read port A |
| rd_b_idx | input | 7 | Logical register number, read port B |
| rd_b_data | output | 64 | Data, read port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 7 | Logical register number to write |
| wr_data | input | 64 | Write data |
| rot_step | input | 1 | Rotate strobe; lowers the base by one |
| base_wr_en | input | 1 | Direct base load enable |
| base_wr_val | input | 7 | Value for the direct load, reduced mod 96 |
| rot_base | output | 7 | Current rename base |

## Verification
Read data is due in the cycle in which the index is applied, because the read path contains no register. A write, rotate, base load or reset is due one rising edge later: the new contents and the new `rot_base` appear in the cycle after the one that drove them. The bench drives all inputs on the falling edge and records the expected values in a queue at that moment. A monitor compares them 2 ns later, before the next rising edge, so each check sees the state created by the earlier edges and none of the effects of the stimulus it was queued with.

// File: rtl/rotreg_pkg.sv
`timescale 1ns/1ps
package rotreg_pkg;
    localparam int DEF_NUM_REGS  = 128;
    localparam int DEF_NUM_FIXED = 32;
    localparam int DEF_DATA_W    = 64;

    // Update taken by the base register on a clock edge
    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_LOAD = 2'd1,
        BASE_STEP = 2'd2
    } base_op_e;
endpackage

// File: rtl/rrb_ctrl.sv
`timescale 1ns/1ps
module rrb_ctrl #(
    parameter int NUM_REGS  = rotreg_pkg::DEF_NUM_REGS,
    parameter int NUM_FIXED = rotreg_pkg::DEF_NUM_FIXED,
    localparam int IW = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rot_step,
    input  logic          base_wr_en,
    input  logic [IW-1:0] base_wr_val,
    output logic [IW-1:0] base
);
    import rotreg_pkg::*;

    localparam logic [IW-1:0] SPAN   = IW'(NUM_REGS - NUM_FIXED);
    localparam logic [IW-1:0] SPAN_M = IW'(NUM_REGS - NUM_FIXED - 1);

    base_op_e      op;
    logic [IW-1:0] base_nx;

    always_comb begin
        if (base_wr_en)    op = BASE_LOAD;
        else if (rot_step) op = BASE_STEP;
        else               op = BASE_HOLD;
    end

    always_comb begin
        base_nx = base;
        unique case (op)
            BASE_HOLD: base_nx = base;
            BASE_LOAD: base_nx = (base_wr_val >= SPAN) ? base_wr_val - SPAN : base_wr_val;
            BASE_STEP: base_nx = (base == '0) ? SPAN_M : base - 1'b1;
            default:   base_nx = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) base <= '0;
        else     base <= base_nx;
    end
endmodule

// File: rtl/rot_map.sv
`timescale 1ns/1ps
module rot_map #(
    parameter int NUM_REGS  = rotreg_pkg::DEF_NUM_REGS,
    parameter int NUM_FIXED = rotreg_pkg::DEF_NUM_FIXED,
    localparam int IW = $clog2(NUM_REGS)
) (
    input  logic [IW-1:0] log_idx,
    input  logic [IW-1:0] base,
    output logic [IW-1:0] phys_idx
);
    localparam logic [IW:0] FIX_W  = (IW+1)'(NUM_FIXED);
    localparam logic [IW:0] SPAN_W = (IW+1)'(NUM_REGS - NUM_FIXED);

    logic [IW:0] off;

    always_comb begin
        off = ({1'b0, log_idx} - FIX_W) + {1'b0, base};
        if (off >= SPAN_W) off = off - SPAN_W;
        if ({1'b0, log_idx} < FIX_W) phys_idx = log_idx;
        else                         phys_idx = IW'(off + FIX_W);
    end
endmodule

// File: rtl/rf_store.sv
`timescale 1ns/1ps
module rf_store #(
    parameter int NUM_REGS = rotreg_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rotreg_pkg::DEF_DATA_W,
    localparam int IW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_phys,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_a_phys,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IW-1:0]     rd_b_phys,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_phys != '0)) mem[wr_phys] <= wr_data;
    end

    assign rd_a_data = (rd_a_phys == '0) ? '0 : mem[rd_a_phys];
    assign rd_b_data = (rd_b_phys == '0) ? '0 : mem[rd_b_phys];
endmodule

// File: rtl/rot_regfile.sv
`timescale 1ns/1ps
module rot_regfile #(
    parameter int NUM_REGS  = rotreg_pkg::DEF_NUM_REGS,
    parameter int NUM_FIXED = rotreg_pkg::DEF_NUM_FIXED,
    parameter int DATA_W    = rotreg_pkg::DEF_DATA_W,
    localparam int IW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IW-1:0]     rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rot_step,
    input  logic              base_wr_en,
    input  logic [IW-1:0]     base_wr_val,
    output logic [IW-1:0]     rot_base
);
    localparam int NPORT = 3;  // read A, read B, write

    logic [IW-1:0] log_idx  [NPORT];
    logic [IW-1:0] phys_idx [NPORT];

    assign log_idx[0] = rd_a_idx;
    assign log_idx[1] = rd_b_idx;
    assign log_idx[2] = wr_idx;

    rrb_ctrl #(.NUM_REGS(NUM_REGS), .NUM_FIXED(NUM_FIXED)) u_base (
        .clk        (clk),
        .rst        (rst),
        .rot_step   (rot_step),
        .base_wr_en (base_wr_en),
        .base_wr_val(base_wr_val),
        .base       (rot_base)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rot_map #(.NUM_REGS(NUM_REGS), .NUM_FIXED(NUM_FIXED)) u_map (
            .log_idx (log_idx[g]),
            .base    (rot_base),
            .phys_idx(phys_idx[g])
        );
    end

    rf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_phys  (phys_idx[2]),
        .wr_data  (wr_data),
        .rd_a_phys(phys_idx[0]),
        .rd_a_data(rd_a_data),
        .rd_b_phys(phys_idx[1]),
        .rd_b_data(rd_b_data)
    );
endmodule

// File: rtl/rot_regfile_chk.sv
`timescale 1ns/1ps
module rot_regfile_chk #(
    parameter int NUM_REGS  = rotreg_pkg::DEF_NUM_REGS,
    parameter int NUM_FIXED = rotreg_pkg::DEF_NUM_FIXED,
    parameter int DATA_W    = rotreg_pkg::DEF_DATA_W,
    localparam int IW = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst,
    input logic [IW-1:0]     rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [IW-1:0]     rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              rot_step,
    input logic              base_wr_en,
    input logic [IW-1:0]     base_wr_val,
    input logic [IW-1:0]     rot_base
);
    localparam logic [IW-1:0] SPAN   = IW'(NUM_REGS - NUM_FIXED);
    localparam logic [IW-1:0] SPAN_M = IW'(NUM_REGS - NUM_FIXED - 1);

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0)); // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == '0) |-> (rd_b_data == '0)); // R2
    AST_BASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        rot_base < SPAN); // R10
    AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (rot_step && !base_wr_en) |=>
        (rot_base == (($past(rot_base) == '0) ? SPAN_M : $past(rot_base) - 1'b1))); // R5
    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        base_wr_en |=>
        (rot_base == (($past(base_wr_val) >= SPAN) ? $past(base_wr_val) - SPAN
                                                   : $past(base_wr_val)))); // R7
    AST_RESET_BASE: assert property (@(posedge clk)
        rst |=> (rot_base == '0)); // R9
endmodule

bind rot_regfile rot_regfile_chk #(
    .NUM_REGS(NUM_REGS), .NUM_FIXED(NUM_FIXED), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .rot_step(rot_step), .base_wr_en(base_wr_en),
    .base_wr_val(base_wr_val), .rot_base(rot_base)
);

// File: tb/rot_regfile_bench.sv
`timescale 1ns/1ps
module rot_regfile_bench;
    localparam int N    = 128;
    localparam int FIX  = 32;
    localparam int SPAN = N - FIX;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, base_wr_val = '0;
    logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, rot_step = 1'b0, base_wr_en = 1'b0;
    logic [6:0]  rot_base;

    always #4 clk = ~clk;  // 125 MHz

    rot_regfile u_rot_regfile (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rot_step(rot_step), .base_wr_en(base_wr_en),
        .base_wr_val(base_wr_val), .rot_base(rot_base)
    );

    typedef struct {
        int          port;   // 0: read A, 1: read B, 2: base
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [63:0] model [N];
    bit          known [N];
    int          model_base = 0;
    bit          done = 1'b0;

    task automatic shift_up();
        logic [63:0] t  = model[N-1];
        bit          tk = known[N-1];
        for (int i = N - 1; i > FIX; i--) begin
            model[i] = model[i-1];
            known[i] = known[i-1];
        end
        model[FIX] = t;
        known[FIX] = tk;
    endtask

    // Driver: applies one cycle of stimulus and queues the results due in it
    task automatic cycle(input int ra, input int rb, input bit we, input int wi,
                         input logic [63:0] wd, input bit rot, input bit bwe,
                         input int bwv, input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        rd_a_idx = 7'(ra); rd_b_idx = 7'(rb);
        wr_en = we; wr_idx = 7'(wi); wr_data = wd;
        rot_step = rot; base_wr_en = bwe; base_wr_val = 7'(bwv);
        if (known[ra]) begin it.port = 0; it.exp = model[ra]; it.tag = tag; sb_q.push_back(it); end
        if (known[rb]) begin it.port = 1; it.exp = model[rb]; it.tag = tag; sb_q.push_back(it); end
        it.port = 2; it.exp = 64'(model_base); it.tag = {tag, "/R10"}; sb_q.push_back(it);
        if (we && wi != 0) begin model[wi] = wd; known[wi] = 1'b1; end
        if (bwe) begin
            int nb = bwv % SPAN;
            int d  = (model_base - nb + SPAN) % SPAN;
            for (int k = 0; k < d; k++) shift_up();
            model_base = nb;
        end else if (rot) begin
            shift_up();
            model_base = (model_base + SPAN - 1) % SPAN;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rot_step = 1'b0; base_wr_en = 1'b0;
        model_base = 0;
        for (int i = 1; i < N; i++) known[i] = 1'b0;  // contents undefined after reset
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < N; i++)
            cycle(i, N - 1 - i, 0, 0, '0, 0, 0, 0, (i < FIX) ? "R3" : tag);
    endtask

    task automatic fill(input logic [63:0] salt);
        for (int i = 0; i < N; i++)
            cycle((i == 0) ? 0 : i - 1, i, 1, i, {32'(i), 32'(i * 32'h9E37)} ^ salt, 0, 0, 0, "R1");
    endtask

    // Monitor: pops queued expectations before the next rising edge
    initial begin
        item_t       it;
        logic [63:0] act;
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                case (it.port)
                    0:       act = rd_a_data;
                    1:       act = rd_b_data;
                    default: act = 64'(rot_base);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin model[i] = '0; known[i] = (i == 0); end
        do_reset();
        cycle(0, 0, 0, 0, '0, 0, 0, 0, "R9");           // base is 0 out of reset
        fill(64'hA5A5_0000_0000_5A5A);
        cycle(0, 1, 1, 0, 64'hDEAD, 0, 0, 0, "R2");      // write to logical 0
        cycle(0, 0, 0, 0, '0, 0, 0, 0, "R2");
        read_all("R4");
        cycle(32, 127, 0, 0, '0, 1, 0, 0, "R5");         // rotate from 0 wraps to 95
        read_all("R6");
        for (int k = 0; k < 3; k++) cycle(40, 33, 0, 0, '0, 1, 0, 0, "R5");
        read_all("R6");
        cycle(40, 127, 1, 40, 64'h1234_5678_9ABC_DEF0, 1, 0, 0, "R8");
        cycle(41, 40, 0, 0, '0, 0, 0, 0, "R8");
        cycle(5, 100, 1, 100, 64'hCAFE, 0, 1, 100, "R8"); // write alongside base load
        read_all("R7");                                   // base 100 -> 4
        cycle(50, 7, 0, 0, '0, 1, 1, 10, "R7");           // load wins over rotate
        read_all("R7");
        cycle(1, 2, 0, 0, '0, 0, 1, 127, "R7");           // 127 -> 31
        read_all("R4");
        do_reset();
        cycle(0, 0, 0, 0, '0, 0, 0, 0, "R9");
        fill(64'h0F0F_F0F0_0F0F_F0F0);
        read_all("R9");
        @(negedge clk);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule